// File: doc/BRIEF.md
# External Bus Hold Arbiter

This block decides who drives a shared external bus: the local controller or another bus master. Another master asks for the bus by pulling the active-low hold line low. When software has enabled arbitration, the local side lets the current external bus cycle finish. It then acknowledges on the active-low acknowledge line and floats its address, data and control drivers. While the bus is lent out, a local external access is stalled and an active-low bus-request line asks for the bus back. Accesses that use only on-chip resources go on without a stall.

The enable input comes from software. After reset, arbitration is off and the local controller keeps the bus. Once the enable has been seen high, the three arbitration pins stay assigned to arbitration until reset, even if software clears the enable later. Clearing the enable while the bus is lent out does not take the bus back. The grant stays in place until the other master releases hold, and only later requests are refused. In slave mode the acknowledge pin turns into an input. The local side drives the bus only while that input shows a grant, so two controllers can be wired to each other with no glue logic.

Top module: `bus_hold_arbiter`

## Requirements
- R1: During and right after reset: hlda_n_o=1, breq_n_o=1, bus_float_o=0, ext_stall_o=0, pin_own_o=0, hlda_oe_o=0.
- R2: While arb_en_i=0 and the bus is owned locally, a low hold_n_i is never acknowledged: hlda_n_o stays 1 and bus_float_o stays 0.
- R3: If arb_en_i goes to 0 while the bus is lent, hlda_n_o stays 0 until hold_n_i returns high. A hold request made after that is not acknowledged.
- R4: hold_n_i passes through two flops. In master mode with arb_en_i=1, a hold request is granted at the third rising edge after hold_n_i is first sampled low, provided ext_req_i=0 or cycle_end_i=1 at that edge. Otherwise the grant waits for the first such edge. hlda_n_o goes to 0 and bus_float_o goes to 1 at the same edge.
- R5: ext_stall_o equals ext_req_i while bus_float_o=1, and is 0 whenever bus_float_o=0 or ext_req_i=0.
- R6: When ext_req_i=1 while the bus is not owned locally, breq_n_o goes to 0 at the next edge. It stays 0 until the edge at which bus_float_o returns to 0.
- R7: pin_own_o goes to 1 at the first edge that samples arb_en_i=1 and keeps that value until reset. hlda_oe_o = pin_own_o and not slave_mode_i.
- R8: After hold_n_i goes high, two edges after it is first sampled high, hlda_n_o returns to 1 while bus_float_o stays 1. One edge later bus_float_o returns to 0 and breq_n_o returns to 1.
- R9: In slave mode with pin_own_o=1, hlda_n_i is synchronised through two flops. bus_float_o is 0 only while the synchronised hlda_n_i is low, one edge after the second flop. Before pin_own_o is set, the bus stays owned locally.
- R10: In slave mode hlda_n_o is 1 and hlda_oe_o is 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arb_en_i | input | 1 | Software arbitration enable |
| slave_mode_i | input | 1 | 1 = slave mode, 0 = master mode |
| ext_req_i | input | 1 | Local side needs an external bus access |
| cycle_end_i | input | 1 | Last cycle of the current external bus cycle |
| hold_n_i | input | 1 | Active-low hold request from another master (asynchronous) |
| hlda_n_i | input | 1 | Active-low grant input used in slave mode (asynchronous) |
| hlda_n_o | output | 1 | Active-low hold acknowledge (master mode) |
| hlda_oe_o | output | 1 | Drive enable for the acknowledge pin |
| breq_n_o | output | 1 | Active-low request to get the bus back |
| bus_float_o | output | 1 | Puts the address, data and control drivers into high impedance |
| ext_stall_o | output | 1 | Stalls the local external-access path |
| pin_own_o | output | 1 | 1 = arbitration pins assigned to arbitration |

## Verification
The assertions assume that slave_mode_i changes only while reset is held. They also assume that cycle_end_i is raised only while ext_req_i is high. The stimulus sets the mode only inside a reset pulse and always pulses cycle_end_i together with a held ext_req_i. The hold and grant inputs may change at any negative edge. The assertions assume nothing about how they are timed, because both lines pass through the synchroniser.

// File: rtl/bus_arb_pkg.sv
`timescale 1ns/1ps
package bus_arb_pkg;
    typedef enum logic [1:0] {
        BUS_OWNED  = 2'd0,
        BUS_LENT   = 2'd1,
        BUS_RETURN = 2'd2
    } arb_state_e;

    typedef struct packed {
        arb_state_e state;
        logic       breq;
    } arb_regs_t;
endpackage

// File: rtl/bus_arb_sync.sv
`timescale 1ns/1ps
module bus_arb_sync #(
    parameter int                 STAGES    = 2,
    parameter int                 WIDTH     = 1,
    parameter logic [WIDTH-1:0]   RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] stage_d [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_comb stage_d[s] = async_i;
            end else begin : g_next
                always_comb stage_d[s] = stage_q[s-1];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= RESET_VAL;
                else        stage_q[s] <= stage_d[s];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/bus_arb_pin_owner.sv
`timescale 1ns/1ps
module bus_arb_pin_owner (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic own_o
);
    logic own_d, own_q;

    always_comb begin
        own_d = own_q | en_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) own_q <= 1'b0;
        else        own_q <= own_d;
    end

    assign own_o = own_q;
endmodule

// File: rtl/bus_arb_core.sv
`timescale 1ns/1ps
module bus_arb_core
    import bus_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       slave_i,
    input  logic       own_i,
    input  logic       req_i,
    input  logic       cend_i,
    input  logic       hold_act_i,
    input  logic       grant_act_i,
    output arb_state_e state_o,
    output logic       breq_o
);
    arb_regs_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (slave_i) begin
            nxt_d.state = (own_i && !grant_act_i) ? BUS_LENT : BUS_OWNED;
        end else begin
            unique case (cur_q.state)
                BUS_OWNED: begin
                    if (en_i && hold_act_i && (!req_i || cend_i))
                        nxt_d.state = BUS_LENT;
                end
                BUS_LENT: begin
                    if (!hold_act_i)
                        nxt_d.state = BUS_RETURN;
                end
                BUS_RETURN: nxt_d.state = BUS_OWNED;
                default:    nxt_d.state = BUS_OWNED;
            endcase
        end
        nxt_d.breq = (nxt_d.state != BUS_OWNED) && (cur_q.breq || req_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.state <= BUS_OWNED;
            cur_q.breq  <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign state_o = cur_q.state;
    assign breq_o  = cur_q.breq;
endmodule

// File: rtl/bus_hold_arbiter.sv
`timescale 1ns/1ps
module bus_hold_arbiter
    import bus_arb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arb_en_i,
    input  logic slave_mode_i,
    input  logic ext_req_i,
    input  logic cycle_end_i,
    input  logic hold_n_i,
    input  logic hlda_n_i,
    output logic hlda_n_o,
    output logic hlda_oe_o,
    output logic breq_n_o,
    output logic bus_float_o,
    output logic ext_stall_o,
    output logic pin_own_o
);
    localparam int LINES = 2;

    logic [LINES-1:0] lines_sync;
    logic             own;
    logic             breq;
    arb_state_e       state;

    bus_arb_sync #(
        .STAGES   (SYNC_STAGES),
        .WIDTH    (LINES),
        .RESET_VAL({LINES{1'b1}})
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({hold_n_i, hlda_n_i}),
        .sync_o (lines_sync)
    );

    bus_arb_pin_owner u_owner (
        .clk  (clk),
        .rst_n(rst_n),
        .en_i (arb_en_i),
        .own_o(own)
    );

    bus_arb_core u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (arb_en_i),
        .slave_i    (slave_mode_i),
        .own_i      (own),
        .req_i      (ext_req_i),
        .cend_i     (cycle_end_i),
        .hold_act_i (~lines_sync[1]),
        .grant_act_i(~lines_sync[0]),
        .state_o    (state),
        .breq_o     (breq)
    );

    assign bus_float_o = (state != BUS_OWNED);
    assign hlda_n_o    = !((state == BUS_LENT) && !slave_mode_i);
    assign hlda_oe_o   = own && !slave_mode_i;
    assign breq_n_o    = !breq;
    assign ext_stall_o = ext_req_i && bus_float_o;
    assign pin_own_o   = own;
endmodule

// File: rtl/bus_hold_arbiter_chk.sv
`timescale 1ns/1ps
module bus_hold_arbiter_chk (
    input logic clk,
    input logic rst_n,
    input logic slave_mode_i,
    input logic ext_req_i,
    input logic hlda_n_o,
    input logic hlda_oe_o,
    input logic breq_n_o,
    input logic bus_float_o,
    input logic ext_stall_o,
    input logic pin_own_o
);
    AST_FLOAT_WITH_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        !hlda_n_o |-> bus_float_o); // R4

    AST_STALL_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ext_stall_o |-> (ext_req_i && bus_float_o)); // R5

    AST_BREQ_WHILE_AWAY: assert property (@(posedge clk) disable iff (!rst_n)
        !breq_n_o |-> bus_float_o); // R6

    AST_OWN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        pin_own_o |=> pin_own_o); // R7

    AST_NO_GRANT_UNOWNED: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_own_o |-> (hlda_n_o && !bus_float_o)); // R2

    AST_RELEASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_mode_i && $rose(hlda_n_o)) |-> bus_float_o); // R8

    AST_SLAVE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        slave_mode_i |-> (hlda_n_o && !hlda_oe_o)); // R10
endmodule

bind bus_hold_arbiter bus_hold_arbiter_chk u_chk (.*);

// File: tb/bus_hold_arbiter_bench.sv
`timescale 1ns/1ps
module bus_hold_arbiter_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arb_en_i = 1'b0;
    logic slave_mode_i = 1'b0;
    logic ext_req_i = 1'b0;
    logic cycle_end_i = 1'b0;
    logic hold_n_i = 1'b1;
    logic hlda_n_i = 1'b1;
    logic hlda_n_o, hlda_oe_o, breq_n_o, bus_float_o, ext_stall_o, pin_own_o;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    // behavioural reference state
    bit m_h1, m_h2, m_g1, m_g2, m_own, m_breq;
    int m_state; // 0 local, 1 lent, 2 returning
    int m_ns;

    always #2 clk = ~clk;

    bus_hold_arbiter u_bus_hold_arbiter (.*);

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_h1 <= 0; m_h2 <= 0; m_g1 <= 0; m_g2 <= 0;
            m_own <= 0; m_breq <= 0; m_state <= 0;
        end else begin
            m_ns = m_state;
            if (slave_mode_i) m_ns = (m_own && !m_g2) ? 1 : 0;
            else if (m_state == 0) begin
                if (arb_en_i && m_h2 && (!ext_req_i || cycle_end_i)) m_ns = 1;
            end else if (m_state == 1) begin
                if (!m_h2) m_ns = 2;
            end else m_ns = 0;
            m_breq  <= (m_ns != 0) && (m_breq || ext_req_i);
            m_state <= m_ns;
            m_h2 <= m_h1; m_h1 <= !hold_n_i;
            m_g2 <= m_g1; m_g1 <= !hlda_n_i;
            m_own <= m_own || arb_en_i;
        end
    end

    task automatic cmp(input string tag, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            cmp("R4 hlda_n_o model", hlda_n_o, !(m_state == 1 && !slave_mode_i));
            cmp("R8 bus_float_o model", bus_float_o, m_state != 0);
            cmp("R6 breq_n_o model", breq_n_o, !m_breq);
            cmp("R5 ext_stall_o model", ext_stall_o, ext_req_i && (m_state != 0));
            cmp("R7 pin_own_o model", pin_own_o, m_own);
            cmp("R7 hlda_oe_o model", hlda_oe_o, m_own && !slave_mode_i);
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic look(input int n);
        cyc(n);
        #1;
    endtask

    task automatic do_reset(input logic slave);
        @(negedge clk);
        rst_n = 1'b0;
        slave_mode_i = slave;
        arb_en_i = 0; ext_req_i = 0; cycle_end_i = 0; hold_n_i = 1; hlda_n_i = 1;
        look(2);
        cmp("R1 reset hlda_n_o", hlda_n_o, 1'b1);
        cmp("R1 reset breq_n_o", breq_n_o, 1'b1);
        cmp("R1 reset bus_float_o", bus_float_o, 1'b0);
        cmp("R1 reset pin_own_o", pin_own_o, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        look(1);
        cmp("R1 after reset ext_stall_o", ext_stall_o, 1'b0);
        cmp("R1 after reset hlda_oe_o", hlda_oe_o, 1'b0);
    endtask

    initial begin
        do_reset(1'b0);

        // R2: disabled arbitration ignores hold
        @(negedge clk); hold_n_i = 0;
        look(6);
        cmp("R2 hlda_n_o disabled", hlda_n_o, 1'b1);
        cmp("R2 bus_float_o disabled", bus_float_o, 1'b0);
        cmp("R7 pin_own_o before enable", pin_own_o, 1'b0);
        @(negedge clk); hold_n_i = 1;
        cyc(3);

        // R4: grant waits for the end of the running cycle
        arb_en_i = 1; ext_req_i = 1; hold_n_i = 0;
        look(2);
        cmp("R7 pin_own_o after enable", pin_own_o, 1'b1);
        look(4);
        cmp("R4 hlda_n_o waits for cycle end", hlda_n_o, 1'b1);
        @(negedge clk); cycle_end_i = 1;
        @(negedge clk); cycle_end_i = 0;
        #1;
        cmp("R4 hlda_n_o granted", hlda_n_o, 1'b0);
        cmp("R4 bus_float_o with grant", bus_float_o, 1'b1);
        cmp("R5 ext_stall_o while lent", ext_stall_o, 1'b1);
        cmp("R6 breq_n_o while lent", breq_n_o, 1'b0);
        @(negedge clk); ext_req_i = 0;
        #1;
        cmp("R5 ext_stall_o internal only", ext_stall_o, 1'b0);

        // R8: release order
        @(negedge clk); hold_n_i = 1;
        look(2);
        cmp("R8 hlda_n_o still low", hlda_n_o, 1'b0);
        look(1);
        cmp("R8 hlda_n_o released first", hlda_n_o, 1'b1);
        cmp("R8 bus_float_o still set", bus_float_o, 1'b1);
        cmp("R6 breq_n_o held until regained", breq_n_o, 1'b0);
        look(1);
        cmp("R8 bus_float_o cleared", bus_float_o, 1'b0);
        cmp("R6 breq_n_o released", breq_n_o, 1'b1);
        cyc(2);

        // R4: exact grant timing with no running cycle
        hold_n_i = 0;
        look(2);
        cmp("R4 hlda_n_o before third edge", hlda_n_o, 1'b1);
        look(1);
        cmp("R4 hlda_n_o at third edge", hlda_n_o, 1'b0);

        // R3: disable while lent defers
        @(negedge clk); arb_en_i = 0;
        look(5);
        cmp("R3 hold continues after disable", hlda_n_o, 1'b0);
        @(negedge clk); hold_n_i = 1;
        look(6);
        cmp("R3 hold ended", hlda_n_o, 1'b1);
        @(negedge clk); hold_n_i = 0;
        look(6);
        cmp("R3 later hold ignored", hlda_n_o, 1'b1);
        cmp("R3 bus kept after disable", bus_float_o, 1'b0);
        cmp("R7 pin_own_o sticky", pin_own_o, 1'b1);
        @(negedge clk); hold_n_i = 1;
        cyc(3);

        // R9, R10: slave mode
        do_reset(1'b1);
        look(3);
        cmp("R9 slave owns bus before enable", bus_float_o, 1'b0);
        @(negedge clk); arb_en_i = 1;
        look(3);
        cmp("R9 slave floats without grant", bus_float_o, 1'b1);
        cmp("R10 slave hlda_oe_o", hlda_oe_o, 1'b0);
        cmp("R10 slave hlda_n_o", hlda_n_o, 1'b1);
        @(negedge clk); ext_req_i = 1;
        look(2);
        cmp("R9 slave breq_n_o", breq_n_o, 1'b0);
        cmp("R9 slave ext_stall_o", ext_stall_o, 1'b1);
        @(negedge clk); hlda_n_i = 0;
        look(2);
        cmp("R9 slave not yet granted", bus_float_o, 1'b1);
        look(1);
        cmp("R9 slave granted", bus_float_o, 1'b0);
        cmp("R9 slave breq_n_o released", breq_n_o, 1'b1);
        cmp("R9 slave ext_stall_o released", ext_stall_o, 1'b0);
        @(negedge clk); hlda_n_i = 1; ext_req_i = 0;
        look(4);
        cmp("R9 slave grant withdrawn", bus_float_o, 1'b1);
        cmp("R10 slave hlda_n_o end", hlda_n_o, 1'b1);
        cyc(2);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule